// File: doc/BRIEF.md
# Output Change-Flag Register Bank

This block sits at the output side of a wrapped synchronous design that a host steps cycle by cycle over a narrow register bus. It keeps one register per output port, loaded together whenever the capture strobe is high, and beside each register a detector that notes a load which brings in a new value. The detector results are kept as one flag bit per port, and the flags are packed into bus-width words.

Transfers are kept low by reading in a fixed order. After each step the host reads the ceil(NUM_PORTS / BUS_W) flag words, and then reads only the ports whose bits are set. Reading a port clears its flag. The reads for one step therefore come to the number of changed ports plus the flag words. After reset every flag is set, so the first pass fetches every output once.

The address space begins with the flag words at addresses 0 to FLAG_WORDS-1. Port i follows at address FLAG_WORDS+i. Every higher address is empty. Port values are zero-extended to the bus width, so PORT_W must not exceed BUS_W.

Top module: `cfb_change_bank`

## Requirements
- R1: When cap_en is high at a clock edge, each port register loads its slice of port_in (port i is bits i*PORT_W and up). When cap_en is low, every port register keeps its value.
- R2: A capture that loads a value different from the one the register held sets that port's flag. A capture that loads an equal value leaves the flag as it was.
- R3: Address k below FLAG_WORDS returns the flag word k, whose bit j is the flag of port k*BUS_W+j. The bits of the last word above port NUM_PORTS-1 read as 0.
- R4: A read of address FLAG_WORDS+i returns the value of port i, zero-extended in bit 0 upward, and clears flag i. A read of a flag word clears nothing.
- R5: When a capture sets flag i in the same cycle as a read of port i, the flag stays set. The read returns the value held before that capture.
- R6: A synchronous active-high reset sets every flag, clears every port register to 0, and clears rd_data to 0.
- R7: rd_data changes only on the clock edge at which rd_en is high. It then carries the state as it stood before that edge, so it is valid one cycle after the request. Otherwise it holds its value.
- R8: A read of an address at or above FLAG_WORDS+NUM_PORTS returns 0 and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture strobe for all port registers |
| port_in | input | NUM_PORTS*PORT_W | Output values from the wrapped design, one PORT_W slice per port |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address: flag words first, then ports |
| rd_data | output | BUS_W | Registered read word |

## Verification
The assertions assume that cap_en, rd_en, rd_addr and port_in are stable around the clock edge and free of unknowns whenever reset is low. They also assume one read request per cycle at most. The bench drives every input on the falling edge and leaves them at defined values between tasks, so these conditions always hold. Unused addresses are driven on purpose only in the out-of-range scenario. A capture is made to coincide with a read of the same port only in the priority scenario.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

    // Kind of location addressed by a read
    typedef enum logic [1:0] {
        SEL_FLAG = 2'd0,
        SEL_PORT = 2'd1,
        SEL_NONE = 2'd2
    } rd_sel_e;

    typedef struct packed {
        rd_sel_e     kind;
        logic [15:0] idx;
    } rd_dec_t;

    // Number of bus words needed to hold a number of bits
    function automatic int words_for(input int bits, input int width);
        return (bits + width - 1) / width;
    endfunction

    // Address decode: flag words first, then one word per port
    function automatic rd_dec_t decode_addr(input int addr, input int fw, input int n);
        rd_dec_t d;
        if (addr < fw) begin
            d.kind = SEL_FLAG;
            d.idx  = 16'(addr);
        end else if (addr < fw + n) begin
            d.kind = SEL_PORT;
            d.idx  = 16'(addr - fw);
        end else begin
            d.kind = SEL_NONE;
            d.idx  = 16'd0;
        end
        return d;
    endfunction

endpackage

// File: rtl/cfb_port_slot.sv
module cfb_port_slot #(
    parameter int PORT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [PORT_W-1:0] d,
    input  logic              clr,
    output logic [PORT_W-1:0] q,
    output logic              flag
);

    logic changed;
    assign changed = cap_en && (d != q);

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            flag <= 1'b1;
        end else begin
            if (cap_en)
                q <= d;
            if (changed)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end

    // New value captured -> flag visible next cycle
    assert_set_on_change_R2: assert property (@(posedge clk) disable iff (rst)
        (cap_en && (d != q)) |=> flag);

    // Equal capture and no read -> flag untouched
    assert_flag_keep_R2: assert property (@(posedge clk) disable iff (rst)
        (!(cap_en && (d != q)) && !clr) |=> $stable(flag));

    // No strobe -> register holds
    assert_hold_value_R1: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(q));

    // Read without concurrent change clears; with change, set wins
    assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (rst)
        (clr && !(cap_en && (d != q))) |=> !flag);
    assert_set_priority_R5: assert property (@(posedge clk) disable iff (rst)
        (clr && cap_en && (d != q)) |=> flag);

endmodule

// File: rtl/cfb_read_port.sv
module cfb_read_port #(
    parameter int NUM_PORTS = 11,
    parameter int PORT_W    = 6,
    parameter int BUS_W     = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [NUM_PORTS-1:0]        flags,
    input  logic [NUM_PORTS*PORT_W-1:0] q_flat,
    output logic [NUM_PORTS-1:0]        clr_vec,
    output logic [BUS_W-1:0]            rd_data
);
    import cfb_pkg::*;

    localparam int FW        = words_for(NUM_PORTS, BUS_W);
    localparam int LAST_BITS = NUM_PORTS - (FW - 1) * BUS_W;
    localparam logic [BUS_W-1:0] LAST_MASK = BUS_W'((64'd1 << LAST_BITS) - 64'd1);

    rd_dec_t                 dec;
    logic [FW*BUS_W-1:0]     padded;
    logic [BUS_W-1:0]        nxt;

    always_comb begin
        dec = decode_addr(int'(rd_addr), FW, NUM_PORTS);
    end

    always_comb begin
        padded                = '0;
        padded[NUM_PORTS-1:0] = flags;
    end

    // One clear strobe per port
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_clr
        assign clr_vec[i] = rd_en && (dec.kind == SEL_PORT) && (int'(dec.idx) == i);
    end

    always_comb begin
        nxt = '0;
        for (int k = 0; k < FW; k++) begin
            if (dec.kind == SEL_FLAG && int'(dec.idx) == k)
                nxt = padded[k*BUS_W +: BUS_W];
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (dec.kind == SEL_PORT && int'(dec.idx) == p)
                nxt = BUS_W'(q_flat[p*PORT_W +: PORT_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= nxt;
    end

    assert_single_clear_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_vec));

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    assert_pad_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(rd_addr) == FW - 1) |=> ((rd_data & ~LAST_MASK) == '0));

    assert_empty_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(rd_addr) >= FW + NUM_PORTS) |=> (rd_data == '0));

    assert_empty_no_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) >= FW + NUM_PORTS) |-> (clr_vec == '0));

endmodule

// File: rtl/cfb_change_bank.sv
module cfb_change_bank #(
    parameter int NUM_PORTS = 11,
    parameter int PORT_W    = 6,
    parameter int BUS_W     = 8,
    parameter int FLAG_WORDS = cfb_pkg::words_for(NUM_PORTS, BUS_W),
    parameter int ADDR_W    = $clog2(FLAG_WORDS + NUM_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cap_en,
    input  logic [NUM_PORTS*PORT_W-1:0] port_in,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BUS_W-1:0]            rd_data
);

    logic [NUM_PORTS-1:0]        flags;
    logic [NUM_PORTS-1:0]        clr_vec;
    logic [NUM_PORTS*PORT_W-1:0] q_flat;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_slot
        cfb_port_slot #(.PORT_W(PORT_W)) slot_i (
            .clk    (clk),
            .rst    (rst),
            .cap_en (cap_en),
            .d      (port_in[i*PORT_W +: PORT_W]),
            .clr    (clr_vec[i]),
            .q      (q_flat[i*PORT_W +: PORT_W]),
            .flag   (flags[i])
        );
    end

    cfb_read_port #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .BUS_W     (BUS_W),
        .ADDR_W    (ADDR_W)
    ) rdp_i (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .flags   (flags),
        .q_flat  (q_flat),
        .clr_vec (clr_vec),
        .rd_data (rd_data)
    );

    // A flag set while nothing is read or captured stays set
    assert_flags_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !cap_en) |=> $stable(flags));

endmodule

// File: tb/cfb_change_bank_tb_top.sv
module cfb_change_bank_tb_top;

    localparam int N   = 11;
    localparam int PW  = 6;
    localparam int BW  = 8;
    localparam int FW  = (N + BW - 1) / BW;
    localparam int AW  = $clog2(FW + N);

    logic            clk = 1'b0;
    logic            rst;
    logic            cap_en;
    logic [N*PW-1:0] port_in;
    logic            rd_en;
    logic [AW-1:0]   rd_addr;
    logic [BW-1:0]   rd_data;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    logic [PW-1:0] mq [N];
    bit            mf [N];

    always #2 clk = ~clk;

    cfb_change_bank #(.NUM_PORTS(N), .PORT_W(PW), .BUS_W(BW)) dut_i (
        .clk(clk), .rst(rst), .cap_en(cap_en), .port_in(port_in),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] flag_word(input int k);
        logic [BW-1:0] w = '0;
        for (int j = 0; j < BW; j++)
            if (k*BW + j < N) w[j] = mf[k*BW + j];
        return w;
    endfunction

    function automatic logic [BW-1:0] expect_at(input int a);
        if (a < FW) return flag_word(a);
        if (a < FW + N) return BW'(mq[a - FW]);
        return '0;
    endfunction

    // One bus read, checked against the model, model updated afterwards
    task automatic read_chk(input int a, input string req);
        logic [BW-1:0] e;
        e = expect_at(a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, 32'(rd_data), 32'(e));
        if (a >= FW && a < FW + N) mf[a - FW] = 1'b0;
    endtask

    task automatic capture(input logic [N*PW-1:0] v);
        @(negedge clk);
        cap_en = 1'b1; port_in = v;
        @(negedge clk);
        cap_en = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (v[i*PW +: PW] != mq[i]) mf[i] = 1'b1;
            mq[i] = v[i*PW +: PW];
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; cap_en = 1'b0; rd_en = 1'b0; rd_addr = '0; port_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) begin mq[i] = '0; mf[i] = 1'b1; end
        @(negedge clk);
        chk("R6 rd_data after reset", 32'(rd_data), 32'h0);
        read_chk(0, "R6 flag word 0 all set");
        read_chk(FW - 1, "R3/R6 last flag word padded");
        chk("R3 last word value", 32'(rd_data), 32'h07);
        for (int i = 0; i < N; i++) read_chk(FW + i, "R6 port zero after reset");
        for (int k = 0; k < FW; k++) read_chk(k, "R4 flags cleared by port reads");
    endtask

    task automatic t_change_and_fetch;
        logic [N*PW-1:0] v = port_in;
        v[0*PW +: PW] = 6'h2A;
        v[9*PW +: PW] = 6'h15;
        v[10*PW +: PW] = 6'h3F;
        capture(v);
        read_chk(0, "R2 flag word 0 after change");
        read_chk(1, "R2 flag word 1 after change");
        read_chk(1, "R4 flag word read does not clear");
        read_chk(FW + 0, "R1 port 0 value");
        read_chk(FW + 9, "R1 port 9 value");
        read_chk(FW + 10, "R1 port 10 value");
        read_chk(0, "R4 word 0 cleared");
        read_chk(1, "R4 word 1 cleared");
    endtask

    task automatic t_same_value;
        capture(port_in);
        read_chk(0, "R2 equal capture sets nothing w0");
        read_chk(1, "R2 equal capture sets nothing w1");
    endtask

    task automatic t_no_strobe;
        @(negedge clk);
        port_in = ~port_in;
        repeat (2) @(negedge clk);
        read_chk(FW + 3, "R1 port holds without strobe");
        read_chk(0, "R1 no flag without strobe");
        port_in = '0;
        for (int i = 0; i < N; i++) port_in[i*PW +: PW] = mq[i];
    endtask

    task automatic t_set_priority;
        logic [N*PW-1:0] v = port_in;
        logic [PW-1:0]   old = mq[4];
        v[4*PW +: PW] = mq[4] ^ 6'h11;
        @(negedge clk);
        cap_en = 1'b1; port_in = v; rd_en = 1'b1; rd_addr = AW'(FW + 4);
        @(negedge clk);
        cap_en = 1'b0; rd_en = 1'b0;
        chk("R5 read returns pre-capture value", 32'(rd_data), 32'(old));
        mq[4] = v[4*PW +: PW]; mf[4] = 1'b1;
        read_chk(0, "R5 flag kept when set meets clear");
        read_chk(FW + 4, "R5 new value readable");
        read_chk(0, "R5 flag cleared by later read");
    endtask

    task automatic t_empty_addr;
        logic [N*PW-1:0] v = port_in;
        v[1*PW +: PW] = mq[1] + 6'd1;
        capture(v);
        read_chk(FW + N, "R8 first empty address reads 0");
        read_chk((1 << AW) - 1, "R8 top address reads 0");
        read_chk(0, "R8 empty read clears no flag");
        read_chk(FW + 1, "R1 port 1 value");
    endtask

    task automatic t_hold_data;
        logic [BW-1:0] seen;
        read_chk(FW + 1, "R7 read before hold");
        seen = rd_data;
        @(negedge clk);
        rd_addr = '0;
        repeat (3) @(negedge clk);
        chk("R7 rd_data holds without request", 32'(rd_data), 32'(seen));
    endtask

    task automatic t_host_loop;
        logic [31:0] s = 32'h1234_5679;
        for (int it = 0; it < 40; it++) begin
            logic [N*PW-1:0] v;
            for (int i = 0; i < N; i++) v[i*PW +: PW] = mq[i];
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            for (int i = 0; i < N; i++)
                if (s[i]) v[i*PW +: PW] = PW'(s >> (i % 20));
            capture(v);
            for (int k = 0; k < FW; k++) read_chk(k, "R3 flag word in host loop");
            for (int i = 0; i < N; i++)
                if (mf[i]) read_chk(FW + i, "R4 fetch of flagged port");
        end
        for (int k = 0; k < FW; k++) read_chk(k, "R4 all clear after loop");
    endtask

    initial begin
        t_reset();
        t_change_and_fetch();
        t_same_value();
        t_no_strobe();
        t_set_priority();
        t_empty_addr();
        t_hold_data();
        t_host_loop();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule